// File: doc/BRIEF.md
# Display Blink and Feature Control

This block holds the 8-bit feature register of a multiplexed LED display driver. It also produces the blink-gated display-enable signal that the digit scanner uses to blank the display. Register writes come from the serial front end as a one-cycle write strobe with an address and a data byte. Only the low nibble of the address is decoded.

The stored bits select several functions:
- the system clock source;
- the digit decoding style;
- whether the serial interface is enabled;
- blinking, with its period, its first phase and its synchronisation.

One bit does not stay set. It asks for a soft reset of the other control registers, which the block emits as a single-cycle pulse; the bit then clears itself.

A prescaler divides the system clock into half-second ticks. `TICK_CYCLES` sets the length of a tick, so a bench can use a tiny value. The ticks drive a phase toggle whose half-period is one tick or two ticks. Several drivers can be kept in step. The load strobe is passed through a synchroniser and an edge detector. When synchronisation is enabled, each rising edge of the strobe restarts the blink timing.

Top module: `blink_feat_ctrl`

## Requirements
- R1: After reset, `feature_o` is 0x00, `soft_rst_o` is 0 and `disp_on_o` is 1.
- R2: A write is accepted when `wr_en_i` is high and `wr_addr_i[3:0]` equals 0xE, whatever the upper address bits are. The new value shows on `feature_o` from the cycle after that edge. A write strobe to any other low nibble leaves `feature_o` unchanged.
- R3: The single-bit outputs follow the feature bits, with bit 0 as the LSB:
  - `ext_clk_o` is bit 0 (1 selects the external clock);
  - `hex_mode_o` is bit 2 (1 selects hex decoding, 0 selects Code-B decoding);
  - `serial_en_o` is bit 3.
- R4: An accepted write with bit 1 set does two things in the single cycle after the write edge: `soft_rst_o` is high and `feature_o[1]` reads 1. In the following cycle, if no further such write occurs, both return to 0 and the other bits keep their written values.
- R5: While bit 4 (blink enable) is 0, `disp_on_o` is 1, whatever the state of bits 5 to 7.
- R6: While blinking is enabled, `disp_on_o` alternates between phases of equal length:
  - `TICK_CYCLES` cycles each when bit 5 is 0;
  - 2*`TICK_CYCLES` cycles each when bit 5 is 1.
- R7: The write that sets bit 4 starts the timer from zero. From the cycle after that write edge, the first phase is on when bit 7 is 1 and off when bit 7 is 0.
- R8: With bit 6 set, a rising edge of `load_i` restarts the timer. If `load_i` is first sampled high at clock edge A, the first phase selected by bit 7 begins in the cycle after edge A+2. With bit 6 clear, a rising edge has no effect. A falling edge never has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | ADDR_W | Register address; low nibble decoded |
| wr_data_i | input | 8 | Write data |
| load_i | input | 1 | Load strobe, asynchronous |
| feature_o | output | 8 | Current feature register contents |
| ext_clk_o | output | 1 | External clock select |
| hex_mode_o | output | 1 | 1 = hex decode, 0 = Code-B decode |
| serial_en_o | output | 1 | Serial interface enable |
| soft_rst_o | output | 1 | One-cycle reset request for the other control registers |
| disp_on_o | output | 1 | Blink-gated display enable |

## Verification
The assertions assume three things about the inputs:
- the write strobe, address and data are synchronous to `clk_i`;
- the write inputs carry defined values from the release of reset onward;
- only `load_i` may change asynchronously.

The stimulus holds the write inputs at zero during reset and drives every input away from the sampling edge. It raises `load_i` only after the previous edge has passed through the synchroniser. That keeps the edge detector from seeing two edges merged into one.

// File: rtl/blink_feat_pkg.sv
package blink_feat_pkg;
  localparam int unsigned FEAT_W = 8;
  localparam logic [3:0] FEAT_ADDR = 4'hE;

  localparam int unsigned B_EXT_CLK = 0;
  localparam int unsigned B_SOFT_RST = 1;
  localparam int unsigned B_HEX = 2;
  localparam int unsigned B_SERIAL = 3;
  localparam int unsigned B_BLINK_EN = 4;
  localparam int unsigned B_SLOW = 5;
  localparam int unsigned B_SYNC = 6;
  localparam int unsigned B_START_ON = 7;
endpackage

// File: rtl/blink_feat_reg.sv
module blink_feat_reg
  import blink_feat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [FEAT_W-1:0] wr_data_i,
  output logic [FEAT_W-1:0] feat_o
);
  logic              wr_hit;
  logic [FEAT_W-1:0] feat_q;

  assign wr_hit = wr_en_i && (wr_addr_i[3:0] == FEAT_ADDR);

  // the soft reset bit lives for one cycle only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      feat_q <= '0;
    end else if (wr_hit) begin
      feat_q <= wr_data_i;
    end else begin
      feat_q[B_SOFT_RST] <= 1'b0;
    end
  end

  assign feat_o = feat_q;

  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(feat_q[B_SOFT_RST]) |-> $past(wr_hit && wr_data_i[B_SOFT_RST])); // R4
  AST_RST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_q[B_SOFT_RST] && !wr_hit) |=> !feat_q[B_SOFT_RST]); // R4
  AST_MISS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> (feat_q[7:2] == $past(feat_q[7:2])) && (feat_q[0] == $past(feat_q[0]))); // R2
endmodule

// File: rtl/blink_load_sync.sv
module blink_load_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], load_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int unsigned TICK_CYCLES = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_i,
  input  logic sync_i,
  input  logic rise_i,
  output logic phase_o
);
  localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic             half_q;
  logic             phase_q;
  logic             clr;
  logic             tick;

  assign clr  = !en_i || (sync_i && rise_i);
  assign tick = (pre_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      half_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (clr) begin
      pre_q   <= '0;
      half_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (tick) begin
      pre_q <= '0;
      // long phase waits for a second tick
      if (half_q || !slow_i) begin
        phase_q <= ~phase_q;
        half_q  <= 1'b0;
      end else begin
        half_q <= 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  AST_PRESCALE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_MAX); // R6
  AST_PHASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && !tick) |=> $stable(phase_q)); // R6
  AST_CLEAR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!phase_q && pre_q == '0)); // R8
endmodule

// File: rtl/blink_feat_ctrl.sv
module blink_feat_ctrl
  import blink_feat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned TICK_CYCLES = 12_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              load_i,
  output logic [7:0]        feature_o,
  output logic              ext_clk_o,
  output logic              hex_mode_o,
  output logic              serial_en_o,
  output logic              soft_rst_o,
  output logic              disp_on_o
);
  logic [FEAT_W-1:0] feat;
  logic              load_rise;
  logic              phase;

  blink_feat_reg #(.ADDR_W(ADDR_W)) i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .feat_o    (feat)
  );

  blink_load_sync #(.STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .rise_o (load_rise)
  );

  blink_timer #(.TICK_CYCLES(TICK_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (feat[B_BLINK_EN]),
    .slow_i  (feat[B_SLOW]),
    .sync_i  (feat[B_SYNC]),
    .rise_i  (load_rise),
    .phase_o (phase)
  );

  assign feature_o   = feat;
  assign ext_clk_o   = feat[B_EXT_CLK];
  assign hex_mode_o  = feat[B_HEX];
  assign serial_en_o = feat[B_SERIAL];
  assign soft_rst_o  = feat[B_SOFT_RST];
  // timer phase 0 shows the chosen start phase
  assign disp_on_o   = !feat[B_BLINK_EN] || (phase ^ feat[B_START_ON]);
endmodule

// File: tb/test_blink_feat_ctrl.sv
module test_blink_feat_ctrl;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       load = 1'b0;
  logic [7:0] feature;
  logic       ext_clk, hex_mode, serial_en, soft_rst, disp_on;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  blink_feat_ctrl #(.ADDR_W(8), .TICK_CYCLES(T)) i_blink_feat_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .load_i(load), .feature_o(feature),
    .ext_clk_o(ext_clk), .hex_mode_o(hex_mode), .serial_en_o(serial_en),
    .soft_rst_o(soft_rst), .disp_on_o(disp_on)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ends at the negedge just after the write edge
  task automatic write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  function automatic int exp_on(input int start, input int slow, input int k);
    int len = T * (slow ? 2 : 1);
    return start ^ ((k / len) % 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 feature", feature, 0);
    check("R1 soft_rst", soft_rst, 0);
    check("R1 disp_on", disp_on, 1);

    // R3 field sweep, soft reset bit kept clear
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v) & 8'hFD;
      write(8'h0E, d);
      check("R3 feature", feature, d);
      check("R3 ext_clk", ext_clk, d[0]);
      check("R3 hex_mode", hex_mode, d[2]);
      check("R3 serial_en", serial_en, d[3]);
    end

    // R2 upper nibble ignored
    for (int u = 0; u < 16; u++) begin
      logic [7:0] d;
      d = 8'(u * 17) & 8'hFD;
      write({4'(u), 4'hE}, d);
      check("R2 upper nibble", feature, d);
    end
    write(8'h0E, 8'h5C);
    for (int lo = 0; lo < 16; lo++) begin
      if (lo != 14) begin
        write({4'(lo), 4'(lo)}, 8'hA3);
        check("R2 other address", feature, 8'h5C);
        @(negedge clk);
        check("R2 other address", feature, 8'h5C);
      end
    end

    // R4 soft reset pulse
    write(8'h0E, 8'h00);
    check("R4 idle", soft_rst, 0);
    write(8'h0E, 8'h06);
    check("R4 pulse", soft_rst, 1);
    check("R4 bit set", feature, 8'h06);
    @(negedge clk);
    check("R4 pulse end", soft_rst, 0);
    check("R4 bit cleared", feature, 8'h04);
    @(negedge clk);
    check("R4 stays low", soft_rst, 0);

    // R5 blink disabled
    write(8'h0E, 8'hE0);
    for (int k = 0; k < 40; k++) begin
      check("R5 ungated", disp_on, 1);
      @(negedge clk);
    end

    // R6 / R7 periods and start phase
    for (int s = 0; s < 2; s++) begin
      for (int sl = 0; sl < 2; sl++) begin
        write(8'h0E, 8'h00);
        write(8'h0E, 8'(8'h10 | (s << 7) | (sl << 5)));
        for (int k = 0; k < 5 * T * 2; k++) begin
          if (k == 0) check("R7 first phase", disp_on, s);
          else check(sl ? "R6 slow period" : "R6 fast period", disp_on, exp_on(s, sl, k));
          @(negedge clk);
        end
      end
    end

    // R8 load-edge synchronisation
    for (int sy = 0; sy < 2; sy++) begin
      int k0;
      k0 = 6;
      write(8'h0E, 8'h00);
      write(8'h0E, 8'(8'h90 | (sy << 6)));
      for (int k = 0; k < 48; k++) begin
        int rel;
        rel = (sy == 1 && k >= k0 + 3) ? k - (k0 + 3) : k;
        check(sy ? "R8 sync restart" : "R8 sync off", disp_on, exp_on(1, 0, rel));
        if (k == k0) load = 1'b1;
        if (k == 22) load = 1'b0;
        @(negedge clk);
      end
      repeat (4) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule